// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block drives an active-low system reset from two sources. The first is a digital power-good level coming from an external supply monitor. The second is a watchdog timer that software services through falling edges on a line that also serves as an SPI chip select. Both sources end the same way: the reset output is held for a fixed stretch after its cause clears, so the rest of the chip always sees a reset pulse of at least that length.

The block counts time in ticks of a prescaled millisecond strobe, `ms_tick`, which is synchronous to `clk`. Power-good may change at any time. Its loss asserts reset at once, through an asynchronous path. Its return is synchronized before the hold period starts. The kick line passes through a synchronizer. Only its high-to-low transitions restart the watchdog, so a line that stays high or stays low for longer than the selected period trips a reset. The two-bit select chooses one of three periods, and its fourth code turns the watchdog off. A sticky flag tells software whether the most recent reset came from the watchdog or from power.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `pwr_good` is 0, `sys_rst_n` is 0 and `rst_by_wdog` is 0. Both take these values as soon as `pwr_good` falls, without waiting for a clock edge.
- R2: When `pwr_good` rises and `ms_tick` is 1 on every cycle, `sys_rst_n` is still 0 after HOLD_TICKS+1 rising clock edges and becomes 1 on edge HOLD_TICKS+2. This is two synchronizer stages followed by HOLD_TICKS ticks (default 200).
- R3: The reset hold period advances only on cycles where `ms_tick` is 1. With `ms_tick` held at 0, reset stays asserted indefinitely.
- R4: A 1-to-0 transition on `cs_kick_n` clears the watchdog count two clock edges later. After the first edge that samples the low level, reset does not assert before edge L+3, where L is the selected period in ticks.
- R5: With the watchdog enabled and no kick, reset asserts exactly L tick-edges after reset was released, or L+3 edges after the last kicking transition, when the line stays high.
- R6: A line held low trips in the same way as a line held high, and a 0-to-1 transition does not restart the count.
- R7: `wd_sel` selects the period L: 2'b00 gives SEL0_TICKS (1400), 2'b01 gives SEL1_TICKS (600), and 2'b10 gives SEL2_TICKS (200).
- R8: When `wd_en` is 0 or `wd_sel` is 2'b11, the watchdog never asserts reset and its count stays at zero. A later enable starts the full period L from zero.
- R9: A watchdog-caused reset lasts exactly HOLD_TICKS ticks. After release, the count restarts from zero, so the next trip without a kick comes L ticks later.
- R10: `rst_by_wdog` goes to 1 when the watchdog trips and stays 1 until power-good is next lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| ms_tick | input | 1 | One-cycle strobe per millisecond, synchronous to clk |
| pwr_good | input | 1 | Asynchronous supply-good level; 0 means supply below threshold |
| cs_kick_n | input | 1 | Shared chip-select / watchdog kick line (asynchronous) |
| wd_en | input | 1 | Watchdog enable |
| wd_sel | input | 2 | Watchdog period select; 2'b11 disables the watchdog |
| sys_rst_n | output | 1 | Active-low system reset |
| rst_by_wdog | output | 1 | 1 if the most recent reset came from the watchdog |

## Verification
The watchdog is exercised with a line stuck high, a line stuck low and then released, single-cycle low kick pulses, and a disabled timer under both ways of disabling it. The stuck cases separate level sensing from edge sensing. The directed kick placed exactly at the boundary pins down the two-cycle synchronizer latency. Random kick gaps, drawn from bands that lie just inside and just outside the period for each randomly chosen select value, distinguish the three select codes and off-by-one errors in the trip comparison. Power cycles with a stalled tick, and power cycles in the middle of a watchdog reset, separate the tick-driven hold count from the cause flag's clearing.

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog #(
  parameter int HOLD_TICKS = 200,
  parameter int SEL0_TICKS = 1400,
  parameter int SEL1_TICKS = 600,
  parameter int SEL2_TICKS = 200
) (
  input  logic       clk,
  input  logic       ms_tick,
  input  logic       pwr_good,
  input  logic       cs_kick_n,
  input  logic       wd_en,
  input  logic [1:0] wd_sel,
  output logic       sys_rst_n,
  output logic       rst_by_wdog
);

  localparam int MAXT = (SEL0_TICKS > SEL1_TICKS) ?
                        ((SEL0_TICKS > SEL2_TICKS) ? SEL0_TICKS : SEL2_TICKS) :
                        ((SEL1_TICKS > SEL2_TICKS) ? SEL1_TICKS : SEL2_TICKS);
  localparam int CW = $clog2(MAXT + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);

  logic [1:0]    pg_sync;
  logic [2:0]    cs_sync;
  logic          pg_ok, kick, wd_active, in_rst, cause;
  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] wd_cnt, wd_limit;

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) pg_sync <= '0;
    else           pg_sync <= {pg_sync[0], 1'b1};

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) cs_sync <= '0;
    else           cs_sync <= {cs_sync[1:0], cs_kick_n};

  assign pg_ok     = pg_sync[1];
  assign kick      = cs_sync[2] & ~cs_sync[1];
  assign wd_active = wd_en && (wd_sel != 2'b11);

  always_comb
    case (wd_sel)
      2'b01:   wd_limit = CW'(SEL1_TICKS);
      2'b10:   wd_limit = CW'(SEL2_TICKS);
      default: wd_limit = CW'(SEL0_TICKS);
    endcase

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good) begin
      in_rst   <= 1'b1;
      hold_cnt <= '0;
      wd_cnt   <= '0;
      cause    <= 1'b0;
    end else if (!pg_ok) begin
      in_rst   <= 1'b1;
      hold_cnt <= '0;
      wd_cnt   <= '0;
      cause    <= 1'b0;
    end else if (in_rst) begin
      wd_cnt <= '0;
      if (ms_tick) begin
        if (hold_cnt == HW'(HOLD_TICKS - 1)) begin
          in_rst   <= 1'b0;
          hold_cnt <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end
    end else if (!wd_active || kick) begin
      wd_cnt <= '0;
    end else if (ms_tick) begin
      if (wd_cnt >= wd_limit - 1'b1) begin
        in_rst <= 1'b1;
        cause  <= 1'b1;
        wd_cnt <= '0;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end

  assign sys_rst_n   = ~in_rst;
  assign rst_by_wdog = cause;

  p_pg_low_holds_rst_r1: assert property (@(posedge clk) disable iff (!pwr_good)
    !pg_ok |-> in_rst && !cause);

  p_hold_in_range_r2: assert property (@(posedge clk) disable iff (!pwr_good)
    hold_cnt < HW'(HOLD_TICKS));

  p_hold_waits_tick_r3: assert property (@(posedge clk) disable iff (!pwr_good)
    (in_rst && pg_ok && !ms_tick) |=> (in_rst && $stable(hold_cnt)));

  p_kick_clears_r4: assert property (@(posedge clk) disable iff (!pwr_good)
    (kick && !in_rst && pg_ok) |=> (wd_cnt == '0));

  p_no_trip_when_off_r8: assert property (@(posedge clk) disable iff (!pwr_good)
    (!wd_active && !in_rst && pg_ok) |=> !in_rst);

  p_release_from_zero_r9: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(sys_rst_n) |-> (wd_cnt == '0));

  p_cause_with_rst_r10: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(cause) |-> in_rst);

endmodule

// File: tb/sup_reset_wdog_tb.sv
module sup_reset_wdog_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 200;
  localparam int S0 = 1400, S1 = 600, S2 = 200;

  logic clk = 1'b0;
  logic ms_tick, pwr_good, cs_kick_n, wd_en;
  logic [1:0] wd_sel;
  logic sys_rst_n, rst_by_wdog;
  int n_chk = 0, n_bad = 0;

  sup_reset_wdog #(.HOLD_TICKS(HOLD), .SEL0_TICKS(S0), .SEL1_TICKS(S1), .SEL2_TICKS(S2)) u_dut (
    .clk(clk), .ms_tick(ms_tick), .pwr_good(pwr_good), .cs_kick_n(cs_kick_n),
    .wd_en(wd_en), .wd_sel(wd_sel), .sys_rst_n(sys_rst_n), .rst_by_wdog(rst_by_wdog));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int limit_of(logic [1:0] s);
    case (s)
      2'b00: return S0;
      2'b01: return S1;
      default: return S2;
    endcase
  endfunction

  function automatic logic exp_after_kick(int n, int l);
    return (n >= l + 3) ? 1'b0 : 1'b1;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_release();
    for (int i = 0; i < HOLD + 10; i++) begin
      if (sys_rst_n) return;
      step(1);
    end
  endtask

  task automatic kick_pulse();
    cs_kick_n = 1'b0;
    step(1);
    cs_kick_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic lowseen;
    int l;
    void'($urandom(32'h1f3a5c71));
    pwr_good = 1'b0; ms_tick = 1'b0; cs_kick_n = 1'b1; wd_en = 1'b1; wd_sel = 2'b10;
    step(3);
    chk("R1 reset state rst", sys_rst_n, 1'b0);
    chk("R1 reset state cause", rst_by_wdog, 1'b0);

    // R3: hold count needs ticks
    pwr_good = 1'b1;
    step(500);
    chk("R3 no tick keeps rst", sys_rst_n, 1'b0);
    ms_tick = 1'b1;
    step(HOLD - 1);
    chk("R3 hold not done", sys_rst_n, 1'b0);
    step(1);
    chk("R3 release after ticks", sys_rst_n, 1'b1);

    // R5 stuck high from release, sel 10
    step(S2 - 1);
    chk("R5 stuck high before", sys_rst_n, 1'b1);
    step(1);
    chk("R5 stuck high trip", sys_rst_n, 1'b0);
    chk("R10 cause set", rst_by_wdog, 1'b1);

    // R9 duration and restart
    step(HOLD - 1);
    chk("R9 wd reset still low", sys_rst_n, 1'b0);
    step(1);
    chk("R9 wd reset released", sys_rst_n, 1'b1);
    chk("R10 cause sticky", rst_by_wdog, 1'b1);
    step(S2 - 1);
    chk("R9 restart before", sys_rst_n, 1'b1);
    step(1);
    chk("R9 restart trip", sys_rst_n, 1'b0);
    step(HOLD);

    // R6 stuck low
    cs_kick_n = 1'b0;
    step(S2 + 2);
    chk("R6 stuck low before", sys_rst_n, 1'b1);
    step(1);
    chk("R6 stuck low trip", sys_rst_n, 1'b0);
    wait_release();
    step(50);
    cs_kick_n = 1'b1;
    step(S2 - 51);
    chk("R6 rise no restart before", sys_rst_n, 1'b1);
    step(1);
    chk("R6 rise no restart trip", sys_rst_n, 1'b0);
    wait_release();

    // R7 select mapping
    wd_sel = 2'b00;
    step(S0 - 1);
    chk("R7 sel00 before", sys_rst_n, 1'b1);
    step(1);
    chk("R7 sel00 trip", sys_rst_n, 1'b0);
    wait_release();
    wd_sel = 2'b01;
    step(S1 - 1);
    chk("R7 sel01 before", sys_rst_n, 1'b1);
    step(1);
    chk("R7 sel01 trip", sys_rst_n, 1'b0);
    wait_release();
    wd_sel = 2'b10;

    // R4 boundary and periodic kicks
    kick_pulse();
    step(S2 + 1);
    chk("R4 kick boundary high", sys_rst_n, 1'b1);
    step(1);
    chk("R4 kick boundary trip", sys_rst_n, 1'b0);
    wait_release();
    lowseen = 1'b0;
    for (int k = 0; k < 6; k++) begin
      kick_pulse();
      for (int j = 0; j < S2 - 10; j++) begin
        step(1);
        if (!sys_rst_n) lowseen = 1'b1;
      end
    end
    chk("R4 periodic kicks hold off", lowseen, 1'b0);

    // R4/R5/R7 random gaps
    for (int t = 0; t < 30; t++) begin
      int n;
      l = limit_of(wd_sel);
      if ($urandom_range(1, 0) == 1) n = l - int'($urandom_range(20, 0));
      else n = l + 3 + int'($urandom_range(17, 0));
      kick_pulse();
      step(n - 1);
      chk("R4 R5 random gap", sys_rst_n, exp_after_kick(n, l));
      if (!sys_rst_n) begin
        wait_release();
        wd_sel = 2'($urandom_range(2, 0));
      end
    end
    wd_sel = 2'b10;

    // R8 disable by enable bit and by code 11
    wd_en = 1'b0;
    lowseen = 1'b0;
    for (int j = 0; j < 2000; j++) begin step(1); if (!sys_rst_n) lowseen = 1'b1; end
    chk("R8 wd_en off", lowseen, 1'b0);
    wd_en = 1'b1; wd_sel = 2'b11;
    for (int j = 0; j < 2000; j++) begin step(1); if (!sys_rst_n) lowseen = 1'b1; end
    chk("R8 sel 11 off", lowseen, 1'b0);
    wd_sel = 2'b10;
    step(S2 - 1);
    chk("R8 re-enable from zero before", sys_rst_n, 1'b1);
    step(1);
    chk("R8 re-enable trip", sys_rst_n, 1'b0);
    chk("R10 cause before power loss", rst_by_wdog, 1'b1);

    // R1/R2/R10 power loss during watchdog reset
    step(20);
    pwr_good = 1'b0;
    #1;
    chk("R1 async rst", sys_rst_n, 1'b0);
    chk("R10 cause cleared by power", rst_by_wdog, 1'b0);
    step(7);
    pwr_good = 1'b1;
    step(HOLD + 1);
    chk("R2 hold low", sys_rst_n, 1'b0);
    chk("R10 power cause", rst_by_wdog, 1'b0);
    step(1);
    chk("R2 release", sys_rst_n, 1'b1);

    // R1 while released
    step(30);
    pwr_good = 1'b0;
    #1;
    chk("R1 async from run", sys_rst_n, 1'b0);
    step(S2 + 50);
    chk("R1 held while power low", sys_rst_n, 1'b0);
    chk("R1 cause while power low", rst_by_wdog, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule